// File: doc/BRIEF.md
# Age-Counter LRU Replacement Unit

This block holds the replacement state for a four-way set-associative cache. Each set has four ways. Every way carries a valid flag and a two-bit age. An age of 0 marks the most recently used way. The highest age marks the way that has gone longest without use. The block does not store tags or data. The surrounding cache does the lookup and tells this unit what happened: a hit on a given way, or a fill after a miss. The unit then updates the ages of the addressed set.

In every cycle the unit reads the set named on `set_idx`. One cycle later it reports, on registered outputs, two facts about that set as it stood before that cycle's update:

- the way a fill would replace;
- whether all four ways hold valid blocks.

A fill uses that same way. The output after a fill therefore also names the way that was filled. A single clear input empties every set at once. Driving a hit and a fill in the same cycle is a protocol error. The fill wins, and a registered error flag reports the conflict.

Top module: `lru_age_unit`

## Requirements
- R1: After reset or after `clear_all`, every way of every set is invalid with age 0. A probe of any set then reports `set_full`=0 and `victim_way`=0.
- R2: A fill (`fill_en`=1) to a set with an invalid way places the block in the lowest-numbered invalid way. That way becomes valid with age 0, and every other valid way of the set has its age raised by 1.
- R3: `victim_way`, `set_full` and `conflict_err` are registered. The values present after clock edge N describe the set on `set_idx` in the cycle ending at edge N, as it was before that edge's update.
- R4: In a full set the victim is the way whose age is 3. A fill there gives that way age 0 and raises the age of the other three ways by 1.
- R5: A hit (`hit_en`=1, `hit_way`=w) on a valid way sets the age of w to 0. Valid ways whose age was below the old age of w are raised by 1. All other ages are kept.
- R6: `set_full` is 1 exactly when all four ways of the probed set are valid.
- R7: In a full set the four ages are always a permutation of 0,1,2,3. As a result, four fills in a row to a full set replace four distinct ways.
- R8: When `hit_en` and `fill_en` are both 1, only the fill is applied. `conflict_err` is 1 in the following cycle, and 0 after any cycle without that conflict.
- R9: A hit on an invalid way changes no state.
- R10: A hit or fill changes only the set named on `set_idx`. All other sets are left unchanged.
- R11: `clear_all` takes priority over hit and fill in the same cycle. In the following cycle `set_full`=0, `victim_way`=0 and `conflict_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_all | input | 1 | Invalidate every way of every set in one cycle |
| set_idx | input | IW | Set addressed this cycle |
| hit_en | input | 1 | Lookup hit on `hit_way` |
| hit_way | input | AW | Way that hit |
| fill_en | input | 1 | Miss; fill the victim way of the set |
| victim_way | output | AW | Replacement way of the set sampled last cycle |
| set_full | output | 1 | All ways of the set sampled last cycle were valid |
| conflict_err | output | 1 | Hit and fill were both driven last cycle |

## Verification
Several input patterns are used:

- **Fills into an empty set.** These show that ways are taken in index order and that invalid ways win over age.
- **Hits on the oldest, a middle and the newest way.** These separate the "only lower ages move" rule from a plain increment of every way.
- **Runs of fills on a full set.** These must visit all four ways. This catches a duplicated or lost age.
- **Hits on invalid ways, hit-plus-fill conflicts and clears combined with other operations.** These check the priority and the ignore rules.
- **Untouched sets probed between the other patterns.** These expose writes that leak into other sets.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_HIT   = 2'd1,
    OP_FILL  = 2'd2,
    OP_CLEAR = 2'd3
  } lru_op_e;
endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS = 4,
  parameter int AW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]    valid,
  input  logic [WAYS*AW-1:0] ages,
  output logic [AW-1:0]      victim,
  output logic               full
);
  localparam logic [AW-1:0] OLDEST = AW'(WAYS - 1);

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    full   = &valid;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i] && !found) begin
        victim = AW'(i);
        found  = 1'b1;
      end
    end
    if (full) begin
      for (int i = 0; i < WAYS; i++) begin
        if (ages[i*AW +: AW] == OLDEST) victim = AW'(i);
      end
    end
  end
endmodule

// File: rtl/lru_age_next.sv
module lru_age_next
  import lru_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int AW   = $clog2(WAYS)
) (
  input  lru_op_e            op,
  input  logic [WAYS-1:0]    valid,
  input  logic [WAYS*AW-1:0] ages,
  input  logic [AW-1:0]      hit_way,
  input  logic [AW-1:0]      fill_way,
  output logic [WAYS-1:0]    valid_nxt,
  output logic [WAYS*AW-1:0] ages_nxt
);
  always_comb begin
    logic [AW-1:0] ref_age;
    valid_nxt = valid;
    ages_nxt  = ages;
    ref_age   = ages[hit_way*AW +: AW];
    case (op)
      OP_HIT: begin
        if (valid[hit_way]) begin
          for (int i = 0; i < WAYS; i++) begin
            if (AW'(i) == hit_way)
              ages_nxt[i*AW +: AW] = '0;
            else if (valid[i] && ages[i*AW +: AW] < ref_age)
              ages_nxt[i*AW +: AW] = ages[i*AW +: AW] + 1'b1;
          end
        end
      end
      OP_FILL: begin
        for (int i = 0; i < WAYS; i++) begin
          if (AW'(i) == fill_way) begin
            valid_nxt[i]         = 1'b1;
            ages_nxt[i*AW +: AW] = '0;
          end else if (valid[i]) begin
            ages_nxt[i*AW +: AW] = ages[i*AW +: AW] + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lru_age_unit.sv
module lru_age_unit
  import lru_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int AW   = $clog2(WAYS),
  parameter int IW   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_all,
  input  logic [IW-1:0] set_idx,
  input  logic          hit_en,
  input  logic [AW-1:0] hit_way,
  input  logic          fill_en,
  output logic [AW-1:0] victim_way,
  output logic          set_full,
  output logic          conflict_err
);
  logic [WAYS-1:0]    valid_r [SETS];
  logic [WAYS*AW-1:0] ages_r  [SETS];

  logic [WAYS-1:0]    cur_valid;
  logic [WAYS*AW-1:0] cur_ages;
  logic [WAYS-1:0]    nxt_valid;
  logic [WAYS*AW-1:0] nxt_ages;
  logic [AW-1:0]      pick_way;
  logic               pick_full;
  lru_op_e            op;

  assign cur_valid = valid_r[set_idx];
  assign cur_ages  = ages_r[set_idx];

  always_comb begin
    if (clear_all)    op = OP_CLEAR;
    else if (fill_en) op = OP_FILL;
    else if (hit_en)  op = OP_HIT;
    else              op = OP_IDLE;
  end

  lru_victim_pick #(.WAYS(WAYS), .AW(AW)) u_pick (
    .valid  (cur_valid),
    .ages   (cur_ages),
    .victim (pick_way),
    .full   (pick_full)
  );

  lru_age_next #(.WAYS(WAYS), .AW(AW)) u_next (
    .op        (op),
    .valid     (cur_valid),
    .ages      (cur_ages),
    .hit_way   (hit_way),
    .fill_way  (pick_way),
    .valid_nxt (nxt_valid),
    .ages_nxt  (nxt_ages)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst || op == OP_CLEAR) begin
        valid_r[s] <= '0;
        ages_r[s]  <= '0;
      end else if (op != OP_IDLE && set_idx == IW'(s)) begin
        valid_r[s] <= nxt_valid;
        ages_r[s]  <= nxt_ages;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      victim_way   <= '0;
      set_full     <= 1'b0;
      conflict_err <= 1'b0;
    end else begin
      victim_way   <= pick_way;
      set_full     <= pick_full;
      conflict_err <= hit_en && fill_en;
    end
  end
endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk #(
  parameter int WAYS = 4,
  parameter int AW   = $clog2(WAYS)
) (
  input logic               clk,
  input logic               rst,
  input logic               clear_all,
  input logic               hit_en,
  input logic               fill_en,
  input logic [AW-1:0]      victim_way,
  input logic               set_full,
  input logic               conflict_err,
  input logic [WAYS-1:0]    cur_valid,
  input logic [WAYS*AW-1:0] cur_ages
);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[cur_ages[i*AW +: AW]] = 1'b1;
  end

  assert_err_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_en && fill_en && !clear_all) |=> conflict_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(hit_en && fill_en) |=> !conflict_err);

  assert_clear_out_R11: assert property (@(posedge clk) disable iff (rst)
    clear_all |=> (!set_full && victim_way == '0 && !conflict_err));

  assert_age_perm_R7: assert property (@(posedge clk) disable iff (rst)
    (&cur_valid) |-> (&seen));

  assert_full_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !clear_all |=> (set_full == $past(&cur_valid)));
endmodule

bind lru_age_unit lru_age_chk #(.WAYS(WAYS), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clear_all    (clear_all),
  .hit_en       (hit_en),
  .fill_en      (fill_en),
  .victim_way   (victim_way),
  .set_full     (set_full),
  .conflict_err (conflict_err),
  .cur_valid    (cur_valid),
  .cur_ages     (cur_ages)
);

// File: tb/test_lru_age_unit.sv
module test_lru_age_unit;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int AW   = 2;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear_all = 1'b0;
  logic [IW-1:0] set_idx = '0;
  logic          hit_en = 1'b0;
  logic [AW-1:0] hit_way = '0;
  logic          fill_en = 1'b0;
  logic [AW-1:0] victim_way;
  logic          set_full;
  logic          conflict_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  int mv [SETS][WAYS];
  int ma [SETS][WAYS];

  always #2.5 clk = ~clk;

  lru_age_unit #(.SETS(SETS), .WAYS(WAYS)) i_lru_age_unit (
    .clk(clk), .rst(rst), .clear_all(clear_all), .set_idx(set_idx),
    .hit_en(hit_en), .hit_way(hit_way), .fill_en(fill_en),
    .victim_way(victim_way), .set_full(set_full), .conflict_err(conflict_err)
  );

  function automatic bit m_full(input int s);
    for (int i = 0; i < WAYS; i++) if (mv[s][i] == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_victim(input int s);
    for (int i = 0; i < WAYS; i++) if (mv[s][i] == 0) return i;
    for (int i = 0; i < WAYS; i++) if (ma[s][i] == WAYS - 1) return i;
    return -1;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < WAYS; i++) begin mv[s][i] = 0; ma[s][i] = 0; end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample outputs at the next negedge (R3).
  task automatic step(input int s, input bit h, input int hw, input bit f,
                      input bit c, input string tag);
    int ev; int ef; int ee;
    ev = c ? 0 : m_victim(s);
    ef = c ? 0 : int'(m_full(s));
    ee = (h && f && !c) ? 1 : 0;
    set_idx = IW'(s); hit_en = h; hit_way = AW'(hw); fill_en = f; clear_all = c;
    @(negedge clk);
    check(tag, "victim_way", int'(victim_way), ev);
    check(tag, "set_full", int'(set_full), ef);
    check(tag, "conflict_err", int'(conflict_err), ee);
    if (c) m_clear();
    else if (f) begin
      for (int i = 0; i < WAYS; i++) if (i != ev && mv[s][i] != 0) ma[s][i]++;
      mv[s][ev] = 1; ma[s][ev] = 0;
    end else if (h && mv[s][hw] != 0) begin
      int r; r = ma[s][hw];
      for (int i = 0; i < WAYS; i++)
        if (i != hw && mv[s][i] != 0 && ma[s][i] < r) ma[s][i]++;
      ma[s][hw] = 0;
    end
    hit_en = 0; fill_en = 0; clear_all = 0;
  endtask

  task automatic probe(input int s, input string tag);
    step(s, 0, 0, 0, 0, tag);
  endtask

  task automatic t_reset();
    for (int s = 0; s < SETS; s++) probe(s, "R1");
  endtask

  task automatic t_fill_empty();
    for (int i = 0; i < WAYS; i++) step(1, 0, 0, 1, 0, "R2");
    probe(1, "R6");
    check("R4", "oldest_way_is_0", int'(victim_way), 0);
  endtask

  task automatic t_hits();
    step(1, 1, 2, 0, 0, "R5");
    probe(1, "R5");
    step(1, 1, 0, 0, 0, "R5");
    probe(1, "R5");
    check("R5", "victim_after_hit0", int'(victim_way), 1);
    step(1, 1, 3, 0, 0, "R5");
    probe(1, "R5");
  endtask

  task automatic t_full_miss();
    int seen; seen = 0;
    for (int k = 0; k < WAYS; k++) begin
      step(1, 0, 0, 1, 0, "R4");
      seen |= (1 << victim_way);
    end
    check("R7", "distinct_victims", seen, 15);
    probe(1, "R4");
  endtask

  task automatic t_invalid_hit();
    step(2, 1, 3, 0, 0, "R9");
    step(2, 0, 0, 1, 0, "R9");
    step(2, 1, 2, 0, 0, "R9");
    probe(2, "R9");
    check("R9", "victim_lowest_invalid", int'(victim_way), 1);
  endtask

  task automatic t_conflict();
    step(2, 1, 0, 1, 0, "R8");
    check("R8", "conflict_raised", int'(conflict_err), 1);
    probe(2, "R8");
    check("R8", "conflict_dropped", int'(conflict_err), 0);
  endtask

  task automatic t_independent();
    probe(3, "R10");
    probe(0, "R10");
    for (int i = 0; i < WAYS; i++) step(5, 0, 0, 1, 0, "R10");
    probe(6, "R10");
    probe(5, "R10");
  endtask

  task automatic t_clear();
    step(1, 1, 1, 1, 1, "R11");
    for (int s = 0; s < SETS; s++) probe(s, "R1");
    step(4, 0, 0, 1, 0, "R2");
    probe(4, "R2");
    check("R2", "second_fill_way", int'(victim_way), 1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_empty();
    t_hits();
    t_full_miss();
    t_invalid_hit();
    t_conflict();
    t_independent();
    t_full_miss();
    t_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule